// File: doc/BRIEF.md
# Partitioned Arithmetic and Selective Logic Unit

This block is a 36-bit execution unit that operates on three words: an accumulator word A, an operand word U and a mask word M. It has two families of operations. The first is lane-partitioned addition and subtraction, in which the carry chain is cut so that the word behaves as two independent 18-bit lanes or three independent 12-bit lanes. The second is bitwise selective operations: set, complement, clear, substitute under a mask, and two parity tests that raise a skip flag. Bits are numbered from the right, so bit 0 is the least significant.

A request is accepted with a valid/ready handshake. Its outcome appears on a single registered output stage one clock after acceptance and stays there until the consumer takes it. The consumer applies back-pressure by holding `out_ready` low. While that result is held, `in_ready` is low and no new request enters. When `out_ready` is high, the stage can drain and refill in the same cycle, which gives one result per clock.

The outcome has four parts: the result word, a write-enable, a destination select and the skip flag. The destination select is 0 for the accumulator and 1 for the next register. Multiply, divide, floating point and any register or memory access are outside this block.

Top module: `psl_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Op 0 (lane add, halves) and op 1 (lane subtract, halves) compute bits 17..0 and bits 35..18 as independent fields. Each field wraps modulo 2^18, and no carry or borrow crosses bit 17/18. The result has `res_wr`=1 and `res_to_next`=0.
- R3: Op 2 (lane add, thirds) and op 3 (lane subtract, thirds) compute bits 11..0, 23..12 and 35..24 as independent fields. Each field wraps modulo 2^12. The result has `res_wr`=1 and `res_to_next`=0.
- R4: Op 4 sets, op 5 inverts and op 6 clears each bit of A wherever U has a 1. These give A|U, A^U and A&~U. The result has `res_wr`=1 and `res_to_next`=1.
- R5: Op 7 gives (A & ~M) | (U & M), with `res_wr`=1 and `res_to_next`=1.
- R6: Op 8 raises `skip` when A&U has an even number of ones. Op 9 raises `skip` when A&U has an odd number of ones. For both ops `res_wr`=0, `res_to_next`=0 and `res`=0.
- R7: Ops 10 to 15 produce `res`=0, `res_wr`=0, `res_to_next`=0 and `skip`=0. `skip` is 0 for every op other than 8 and 9.
- R8: `in_ready` equals (not `out_valid`) or `out_ready`. A request accepted at a clock edge shows on the outputs with `out_valid`=1 after that edge. While `out_valid`=1 and `out_ready`=0, all outputs hold their values.
- R9: Input words and op are ignored when `in_valid`=0: no result is produced, and a held result drains without being replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| op | input | 4 | Operation code (see R2 to R7) |
| a_word | input | 36 | Accumulator word A |
| u_word | input | 36 | Operand word U |
| m_word | input | 36 | Mask word M (used by op 7) |
| out_valid | output | 1 | Outcome present |
| out_ready | input | 1 | Consumer takes the outcome |
| res | output | 36 | Result word |
| res_wr | output | 1 | Result is to be written |
| res_to_next | output | 1 | Destination: 0 = A, 1 = next register |
| skip | output | 1 | Parity test succeeded |

## Verification
The reference model predicts all four outcome fields and `out_valid` on every clock. A fault in a lane boundary, such as a carry leaking across bit 17 or bit 11, shows in the result word of the very next outcome whenever an operand pair carries at that boundary. For this reason the directed vectors force all-ones and zero-minus-one patterns in every lane. A fault in the output stage's hold or drain logic shows within one cycle as a changed or duplicated outcome under randomly applied back-pressure. A fault in the op decode shows as a wrong write-enable, destination or skip flag on the first outcome with that op.

// File: rtl/psl_pkg.sv
package psl_pkg;
  localparam int WORD_W  = 36;
  localparam int HALF_W  = WORD_W / 2;
  localparam int THIRD_W = WORD_W / 3;
  localparam int OP_W    = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_HALF = 4'd0,
    OP_SUB_HALF = 4'd1,
    OP_ADD_THRD = 4'd2,
    OP_SUB_THRD = 4'd3,
    OP_SEL_SET  = 4'd4,
    OP_SEL_INV  = 4'd5,
    OP_SEL_CLR  = 4'd6,
    OP_SEL_SUBS = 4'd7,
    OP_PAR_EVEN = 4'd8,
    OP_PAR_ODD  = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    SEL_SET = 2'd0,
    SEL_INV = 2'd1,
    SEL_CLR = 2'd2,
    SEL_SUB = 2'd3
  } sel_e;
endpackage

// File: rtl/psl_lane_adder.sv
module psl_lane_adder #(
  parameter int W      = psl_pkg::WORD_W,
  parameter int LANE_A = psl_pkg::HALF_W,
  parameter int LANE_B = psl_pkg::THIRD_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cut_a,
  input  logic         cut_b,
  output logic [W-1:0] sum
);
  // Boundary bits for each lane width, built once at elaboration.
  logic [W-1:0] edge_a, edge_b;
  for (genvar g = 0; g < W; g++) begin : g_edge
    assign edge_a[g] = ((g % LANE_A) == 0);
    assign edge_b[g] = ((g % LANE_B) == 0);
  end

  always_comb begin
    logic c;
    logic bb;
    c   = sub;
    sum = '0;
    for (int i = 0; i < W; i++) begin
      if ((cut_a && edge_a[i]) || (cut_b && edge_b[i])) c = sub;
      bb     = b[i] ^ sub;
      sum[i] = a[i] ^ bb ^ c;
      c      = (a[i] & bb) | (c & (a[i] ^ bb));
    end
  end
endmodule

// File: rtl/psl_sel_logic.sv
module psl_sel_logic #(
  parameter int W = psl_pkg::WORD_W
) (
  input  psl_pkg::sel_e kind,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  u,
  input  logic [W-1:0]  m,
  output logic [W-1:0]  y
);
  always_comb begin
    unique case (kind)
      psl_pkg::SEL_SET: y = a | u;
      psl_pkg::SEL_INV: y = a ^ u;
      psl_pkg::SEL_CLR: y = a & ~u;
      default:          y = (a & ~m) | (u & m);
    endcase
  end
endmodule

// File: rtl/psl_parity.sv
module psl_parity #(
  parameter int W = psl_pkg::WORD_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] u,
  output logic         odd
);
  assign odd = ^(a & u);
endmodule

// File: rtl/psl_unit.sv
module psl_unit
  import psl_pkg::*;
#(
  parameter int W = psl_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   op,
  input  logic [W-1:0]      a_word,
  input  logic [W-1:0]      u_word,
  input  logic [W-1:0]      m_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      res,
  output logic              res_wr,
  output logic              res_to_next,
  output logic              skip
);
  logic [W-1:0] sum_w, sel_w, nxt_res;
  logic         par_odd, nxt_wr, nxt_next, nxt_skip;
  logic         is_sub, cut_h, cut_t;

  assign is_sub = op[0];
  assign cut_h  = (op == OP_ADD_HALF) || (op == OP_SUB_HALF);
  assign cut_t  = (op == OP_ADD_THRD) || (op == OP_SUB_THRD);

  psl_lane_adder #(.W(W), .LANE_A(W/2), .LANE_B(W/3)) u_add (
    .a(a_word), .b(u_word), .sub(is_sub), .cut_a(cut_h), .cut_b(cut_t), .sum(sum_w)
  );

  psl_sel_logic #(.W(W)) u_sel (
    .kind(sel_e'(op[1:0])), .a(a_word), .u(u_word), .m(m_word), .y(sel_w)
  );

  psl_parity #(.W(W)) u_par (.a(a_word), .u(u_word), .odd(par_odd));

  always_comb begin
    nxt_res  = '0;
    nxt_wr   = 1'b0;
    nxt_next = 1'b0;
    nxt_skip = 1'b0;
    case (op)
      OP_ADD_HALF, OP_SUB_HALF, OP_ADD_THRD, OP_SUB_THRD: begin
        nxt_res = sum_w;
        nxt_wr  = 1'b1;
      end
      OP_SEL_SET, OP_SEL_INV, OP_SEL_CLR, OP_SEL_SUBS: begin
        nxt_res  = sel_w;
        nxt_wr   = 1'b1;
        nxt_next = 1'b1;
      end
      OP_PAR_EVEN: nxt_skip = ~par_odd;
      OP_PAR_ODD:  nxt_skip = par_odd;
      default: ;
    endcase
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      res         <= '0;
      res_wr      <= 1'b0;
      res_to_next <= 1'b0;
      skip        <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        res         <= nxt_res;
        res_wr      <= nxt_wr;
        res_to_next <= nxt_next;
        skip        <= nxt_skip;
      end
    end
  end
endmodule

// File: rtl/psl_checker.sv
module psl_checker #(
  parameter int W = psl_pkg::WORD_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] res,
  input logic         res_wr,
  input logic         res_to_next,
  input logic         skip
);
  // R8: a held outcome does not change
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res) && $stable(res_wr)
                                && $stable(res_to_next) && $stable(skip));

  // R8: acceptance yields an outcome on the next cycle
  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9: no request and a free stage leaves the stage empty
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && (!out_valid || out_ready) |=> !out_valid);

  // R6: a raised skip never comes with a write
  a_r6_skip_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && skip |-> !res_wr);

  // R7: the next-register destination only accompanies a write
  a_r7_dest_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && res_to_next |-> res_wr);
endmodule

bind psl_unit psl_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .res(res), .res_wr(res_wr),
  .res_to_next(res_to_next), .skip(skip)
);

// File: tb/tb_psl_unit.sv
module tb_psl_unit;
  localparam int W = 36;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [3:0] op = '0;
  logic [W-1:0] a_word = '0, u_word = '0, m_word = '0;
  logic in_ready, out_valid, res_wr, res_to_next, skip;
  logic [W-1:0] res;

  int checks = 0, failures = 0;
  bit finished = 0;

  // reference model state
  bit ev = 0, ew = 0, en = 0, es = 0;
  logic [W-1:0] er = '0;
  string etag = "R1";
  bit nv, nw, nn, ns;
  logic [W-1:0] nr;
  string ntag;

  always #5 clk = ~clk;

  psl_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .op(op),
    .a_word(a_word), .u_word(u_word), .m_word(m_word), .out_valid(out_valid),
    .out_ready(out_ready), .res(res), .res_wr(res_wr), .res_to_next(res_to_next),
    .skip(skip)
  );

  function automatic logic [W-1:0] lanes(logic [W-1:0] a, logic [W-1:0] u, bit sub, int lw);
    logic [63:0] acc = 0;
    longint unsigned mask = (64'd1 << lw) - 1;
    for (int k = 0; k * lw < W; k++) begin
      longint unsigned x = (64'(a) >> (k * lw)) & mask;
      longint unsigned y = (64'(u) >> (k * lw)) & mask;
      longint unsigned r = sub ? (x - y) : (x + y);
      acc |= (r & mask) << (k * lw);
    end
    return acc[W-1:0];
  endfunction

  task automatic model(input logic [3:0] o, input logic [W-1:0] a, u, m);
    int ones = $countones(a & u);
    nr = '0; nw = 0; nn = 0; ns = 0;
    case (o)
      0, 1: begin nr = lanes(a, u, o == 1, 18); nw = 1; ntag = "R2"; end
      2, 3: begin nr = lanes(a, u, o == 3, 12); nw = 1; ntag = "R3"; end
      4: begin nr = a | u;  nw = 1; nn = 1; ntag = "R4"; end
      5: begin nr = a ^ u;  nw = 1; nn = 1; ntag = "R4"; end
      6: begin nr = a & ~u; nw = 1; nn = 1; ntag = "R4"; end
      7: begin nr = (a & ~m) | (u & m); nw = 1; nn = 1; ntag = "R5"; end
      8: begin ns = (ones % 2) == 0; ntag = "R6"; end
      9: begin ns = (ones % 2) == 1; ntag = "R6"; end
      default: ntag = "R7";
    endcase
  endtask

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(out_valid == ev, ev ? "R8" : "R9", "out_valid", 64'(out_valid), 64'(ev));
    if (ev && out_valid) begin
      chk(res == er, etag, "res", 64'(res), 64'(er));
      chk(res_wr == ew, etag, "res_wr", 64'(res_wr), 64'(ew));
      chk(res_to_next == en, etag, "res_to_next", 64'(res_to_next), 64'(en));
      chk(skip == es, etag, "skip", 64'(skip), 64'(es));
    end
  endtask

  task automatic cycle(bit v, logic [3:0] o, logic [W-1:0] a, u, m, bit rdy);
    bit mready;
    @(negedge clk);
    compare();
    in_valid = v; op = o; a_word = a; u_word = u; m_word = m; out_ready = rdy;
    #1;
    mready = !ev || rdy;
    chk(in_ready == mready, "R8", "in_ready", 64'(in_ready), 64'(mready));
    nv = ev; nr = er; nw = ew; nn = en; ns = es; ntag = etag;
    if (mready) begin
      nv = v;
      if (v) model(o, a, u, m);
      else begin nr = er; nw = ew; nn = en; ns = es; ntag = etag; end
    end
    @(posedge clk); #1;
    ev = nv; er = nr; ew = nw; en = nn; es = ns; etag = ntag;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1", "out_valid", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R1", "in_ready", 64'(in_ready), 64'd1);

    // R2 halves: carry/borrow must not cross bit 17
    cycle(1, 0, 36'h0_0003_FFFF, 36'h0_0000_0001, '0, 1);
    cycle(1, 1, 36'h0, 36'h0_0000_0001, '0, 1);
    cycle(1, 0, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, '0, 1);
    // R3 thirds: wrap in each 12-bit lane
    cycle(1, 2, 36'hFFF_FFF_FFF, 36'h001_001_001, '0, 1);
    cycle(1, 3, 36'h000_000_000, 36'h001_001_001, '0, 1);
    cycle(1, 2, 36'h800_7FF_FFF, 36'h800_001_001, '0, 1);
    // R4 / R5 selective ops
    cycle(1, 4, 36'h0_F0F0_F0F0, 36'h0_0FF0_0FF0, '0, 1);
    cycle(1, 5, 36'h5_5555_5555, 36'hF_FFFF_0000, '0, 1);
    cycle(1, 6, 36'hF_FFFF_FFFF, 36'hA_AAAA_AAAA, '0, 1);
    cycle(1, 7, 36'h0_0000_0000, 36'hF_FFFF_FFFF, 36'h3_0F0F_0F0F, 1);
    // R6 parity tests: zero ones (even) and one bit (odd)
    cycle(1, 8, 36'h0, 36'hF_FFFF_FFFF, '0, 1);
    cycle(1, 9, 36'h8_0000_0000, 36'h8_0000_0001, '0, 1);
    cycle(1, 8, 36'h0_0000_0007, 36'h0_0000_0007, '0, 1);
    // R7 undefined ops
    cycle(1, 10, 36'h1_2345_6789, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 1);
    cycle(1, 15, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, '0, 1);
    // R8 back-pressure: hold, then a blocked request, then drain
    cycle(1, 4, 36'h1, 36'h2, '0, 0);
    cycle(1, 5, 36'h7, 36'h1, '0, 0);
    cycle(1, 5, 36'h7, 36'h1, '0, 0);
    cycle(1, 5, 36'h7, 36'h1, '0, 1);
    // R9 garbage without valid is ignored
    cycle(0, 0, 36'hF_FFFF_FFFF, 36'h1, '0, 1);
    cycle(0, 7, 36'h1, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 0);

    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] a = {$urandom, $urandom};
      logic [W-1:0] u = {$urandom, $urandom};
      logic [W-1:0] m = {$urandom, $urandom};
      cycle(($urandom % 4) != 0, 4'($urandom % 16), a, u, m, ($urandom % 3) != 0);
    end
    cycle(0, 0, '0, '0, '0, 1);
    @(negedge clk);
    compare();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule